// File: doc/BRIEF.md
# Per-CPU Level Interrupt Router

This block is a first-level interrupt controller. It collects a parameterized group of level-sensitive peripheral interrupt lines and drives one interrupt request wire into each CPU. Each CPU owns a private bank of mask words. A line reaches a CPU only when that CPU's own bank enables it, so software can steer every peripheral to any subset of CPUs.

Next to each mask word, every bank has a read-only pending word. A pending word shows the live input levels ANDed with that CPU's mask. The block does no prioritizing, vectoring, queuing or edge capture. Software scans all the pending words of its bank to find the sources. Because the inputs are levels, a source clears only when the peripheral drops its line.

A simple word-addressed register port reaches every bank. The banks sit one after another in the address space. Each bank is 2×(lines/32) words long, so the bank size follows directly from the line count.

Top module: `l1_irq_router`

## Requirements
- R1: After reset every mask bit is 0, every CPU request output is 0, and every register word reads 0.
- R2: Bit j of pending word k in a CPU's bank reads as input line 32·k+j ANDed with bit j of mask word k in that same bank.
- R3: A CPU's request output rises on the first clock edge where any pending bit of its bank is 1, and falls on the first edge where none is. This is exactly one clock of latency.
- R4: Banks are independent. A line enabled in one CPU's bank and disabled in another's raises only the first CPU's request.
- R5: A write to a mask word replaces all 32 bits with the written data. No bit is set or cleared on its own, and the new value reads back unchanged.
- R6: Writes to pending words have no effect on any mask or pending value.
- R7: Word address = cpu·2W + offset, where W = lines/32. Offsets 0..W−1 are the pending words, in order of increasing line index. Offsets W..2W−1 are the mask words, in the same order.
- R8: Read data appears on the read-data port on the clock edge that samples a read strobe, and it holds until the next read.
- R9: Addresses at or above NUM_CPUS·2W read as 0, and writes to them are ignored.
- R10: Inputs are level-sensitive. When the peripheral releases its line, the request falls with no software access.
- R11: The line count must be 32, 64 or 128, and the address width must cover every bank. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_LINES | Level-sensitive peripheral interrupt inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPUS | One interrupt request per CPU |

## Verification
The bench builds the block with 128 lines and 3 CPUs. With 128 lines each bank holds four pending words and four mask words, so the test reaches the top line (127) and the word offsets past the first. With 3 CPUs the bank count is not a power of two, which leaves an unused tail in the 5-bit address space. That tail is where the out-of-range read and write rules are tested. It also lets a single line be routed to a non-adjacent pair of CPUs while the CPU between them stays quiet.

// File: rtl/l1_route_pkg.sv
package l1_route_pkg;

   localparam int WORD_W = 32;

   typedef enum logic {
      KIND_PENDING = 1'b0,
      KIND_MASK    = 1'b1
   } reg_kind_e;

   function automatic int words_for(input int lines);
      return lines / WORD_W;
   endfunction

   function automatic bit legal_lines(input int lines);
      return (lines == 32) || (lines == 64) || (lines == 128);
   endfunction

endpackage

// File: rtl/l1_route_bank.sv
module l1_route_bank
   import l1_route_pkg::*;
#(
   parameter int NUM_WORDS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WORDS*WORD_W-1:0]   lines_i,
   input  logic [NUM_WORDS-1:0]          mask_we_i,
   input  logic [WORD_W-1:0]             wdata_i,
   output logic [NUM_WORDS*WORD_W-1:0]   mask_o,
   output logic [NUM_WORDS*WORD_W-1:0]   pending_o,
   output logic                          irq_o
);

   localparam int BITS = NUM_WORDS * WORD_W;

   logic [BITS-1:0]      mask_q;
   logic [NUM_WORDS-1:0] word_hit;
   logic                 irq_q;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[w*WORD_W +: WORD_W] <= '0;
         end else if (mask_we_i[w]) begin
            mask_q[w*WORD_W +: WORD_W] <= wdata_i;
         end
      end

      assign pending_o[w*WORD_W +: WORD_W] = lines_i[w*WORD_W +: WORD_W]
                                           & mask_q[w*WORD_W +: WORD_W];
      assign word_hit[w] = |pending_o[w*WORD_W +: WORD_W];

      // R5
      mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mask_we_i[w] |=> mask_q[w*WORD_W +: WORD_W] == $past(wdata_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |word_hit;
   end

   assign mask_o = mask_q;
   assign irq_o  = irq_q;

   // R3
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(lines_i & mask_q)) |=> irq_o);

   // R10
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(lines_i & mask_q)) |=> !irq_o);

   // R6
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|mask_we_i) |=> $stable(mask_q));

endmodule

// File: rtl/l1_route_regif.sv
module l1_route_regif
   import l1_route_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 2,
   parameter int ADDR_W    = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_sel,
   input  logic                            bus_we,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [WORD_W-1:0]               bus_wdata,
   input  logic [NUM_CPUS*NUM_LINES-1:0]   pending_all,
   input  logic [NUM_CPUS*NUM_LINES-1:0]   mask_all,
   output logic [NUM_CPUS*words_for(NUM_LINES)-1:0] mask_we_all,
   output logic [WORD_W-1:0]               bus_rdata
);

   localparam int WPB        = words_for(NUM_LINES);
   localparam int BANK_WORDS = 2 * WPB;
   localparam int TOTAL      = NUM_CPUS * BANK_WORDS;
   localparam int OFF_W      = $clog2(BANK_WORDS);

   logic              in_range;
   logic [OFF_W-1:0]  offset;
   int                cpu_idx;
   int                word_idx;
   reg_kind_e         kind;
   logic              wr_mask;
   logic [WORD_W-1:0] rd_next;
   logic [WORD_W-1:0] rdata_q;

   if (NUM_CPUS == 1) begin : g_one_cpu
      assign cpu_idx = 0;
   end else begin : g_many_cpu
      assign cpu_idx = int'(bus_addr >> OFF_W);
   end

   always_comb begin
      in_range = int'(bus_addr) < TOTAL;
      offset   = bus_addr[OFF_W-1:0];
      kind     = (int'(offset) < WPB) ? KIND_PENDING : KIND_MASK;
      word_idx = (kind == KIND_PENDING) ? int'(offset) : int'(offset) - WPB;
      wr_mask  = bus_sel && bus_we && in_range && (kind == KIND_MASK);
   end

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      for (genvar w = 0; w < WPB; w++) begin : g_wd
         assign mask_we_all[c*WPB + w] = wr_mask && (cpu_idx == c) && (word_idx == w);
      end
   end

   always_comb begin
      rd_next = '0;
      if (in_range) begin
         if (kind == KIND_PENDING)
            rd_next = pending_all[cpu_idx*NUM_LINES + word_idx*WORD_W +: WORD_W];
         else
            rd_next = mask_all[cpu_idx*NUM_LINES + word_idx*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rdata_q <= '0;
      else if (bus_sel && !bus_we) rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;

   // R9
   oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && !in_range) |=> bus_rdata == '0);

   // R9
   oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && !in_range) |-> mask_we_all == '0);

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_we) |=> $stable(bus_rdata));

   // R6
   pending_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && kind == KIND_PENDING) |-> mask_we_all == '0);

   // R5
   single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mask_we_all) <= 1);

endmodule

// File: rtl/l1_irq_router.sv
module l1_irq_router
   import l1_route_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 2,
   parameter int ADDR_W    = $clog2(NUM_CPUS * 2 * (NUM_LINES / 32))
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LINES-1:0]  irq_lines,
   input  logic                  bus_sel,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   output logic [NUM_CPUS-1:0]   cpu_irq
);

   localparam int WPB     = words_for(NUM_LINES);
   localparam int NEED_AW = $clog2(NUM_CPUS * 2 * WPB);

   // R11
   if (!legal_lines(NUM_LINES)) begin : g_bad_lines
      $error("l1_irq_router: NUM_LINES must be 32, 64 or 128");
   end
   if (NUM_CPUS < 1) begin : g_bad_cpus
      $error("l1_irq_router: NUM_CPUS must be at least 1");
   end
   if (ADDR_W < NEED_AW) begin : g_bad_aw
      $error("l1_irq_router: ADDR_W too narrow for all banks");
   end

   logic [NUM_CPUS*NUM_LINES-1:0] pending_all;
   logic [NUM_CPUS*NUM_LINES-1:0] mask_all;
   logic [NUM_CPUS*WPB-1:0]       mask_we_all;

   l1_route_regif #(
      .NUM_LINES (NUM_LINES),
      .NUM_CPUS  (NUM_CPUS),
      .ADDR_W    (ADDR_W)
   ) i_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .pending_all (pending_all),
      .mask_all    (mask_all),
      .mask_we_all (mask_we_all),
      .bus_rdata   (bus_rdata)
   );

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
      l1_route_bank #(
         .NUM_WORDS (WPB)
      ) i_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .lines_i   (irq_lines),
         .mask_we_i (mask_we_all[c*WPB +: WPB]),
         .wdata_i   (bus_wdata),
         .mask_o    (mask_all[c*NUM_LINES +: NUM_LINES]),
         .pending_o (pending_all[c*NUM_LINES +: NUM_LINES]),
         .irq_o     (cpu_irq[c])
      );
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> cpu_irq == '0);

endmodule

// File: tb/test_l1_irq_router.sv
module test_l1_irq_router;

   localparam int NL     = 128;
   localparam int NC     = 3;
   localparam int W      = NL / 32;
   localparam int BW     = 2 * W;
   localparam int AW     = $clog2(NC * BW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_lines = '0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] cpu_irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   l1_irq_router #(.NUM_LINES(NL), .NUM_CPUS(NC)) i_l1_irq_router (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
   );

   typedef struct packed {
      logic [1:0]  cpu;
      logic [1:0]  word;
      logic [31:0] mask;
      logic [31:0] lines;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 2'd0, 32'h0000_00FF, 32'h0000_0F0F, 32'h0000_000F},
      '{2'd1, 2'd1, 32'hFFFF_0000, 32'h8000_0001, 32'h8000_0000},
      '{2'd2, 2'd3, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001},
      '{2'd0, 2'd2, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000},
      '{2'd1, 2'd3, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000},
      '{2'd2, 2'd0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678}
   };

   function automatic int pend_addr(int c, int w);
      return c * BW + w;
   endfunction

   function automatic int mask_addr(int c, int w);
      return c * BW + W + w;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic clear_masks();
      for (int c = 0; c < NC; c++)
         for (int w = 0; w < W; w++)
            bus_write(mask_addr(c, w), 32'h0);
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] ex;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      irq_lines = '1;
      @(negedge clk);
      check("R1", "cpu_irq after reset", 32'(cpu_irq), 32'h0);
      for (int a = 0; a < NC * BW; a++) begin
         bus_read(a, rd);
         check("R1", "word after reset", rd, 32'h0);
      end
      irq_lines = '0;

      // R2 R3 R4 R7: vector table
      foreach (VECS[i]) begin
         clear_masks();
         irq_lines = '0;
         irq_lines[VECS[i].word*32 +: 32] = VECS[i].lines;
         bus_write(mask_addr(VECS[i].cpu, VECS[i].word), VECS[i].mask);
         @(negedge clk);
         ex = (VECS[i].exp != 0) ? (32'h1 << VECS[i].cpu) : 32'h0;
         check("R3", "cpu_irq for vector", 32'(cpu_irq), ex);
         bus_read(pend_addr(VECS[i].cpu, VECS[i].word), rd);
         check("R2", "pending word", rd, VECS[i].exp);
         bus_read(mask_addr(VECS[i].cpu, VECS[i].word), rd);
         check("R7", "mask word position", rd, VECS[i].mask);
         bus_read(pend_addr((VECS[i].cpu + 1) % NC, VECS[i].word), rd);
         check("R4", "other bank pending", rd, 32'h0);
      end

      // R4: same line to CPU 0 and 2, not 1
      clear_masks();
      irq_lines = '0;
      bus_write(mask_addr(0, 1), 32'h0000_0010);
      bus_write(mask_addr(2, 1), 32'h0000_0010);
      bus_write(mask_addr(1, 1), 32'hFFFF_FFEF);
      irq_lines[36] = 1'b1;
      @(negedge clk);
      check("R4", "line 36 routing", 32'(cpu_irq), 32'h5);

      // R3 / R10: one-cycle latency and level release
      irq_lines = '0;
      @(negedge clk);
      check("R10", "release drops irq", 32'(cpu_irq), 32'h0);
      irq_lines[36] = 1'b1;
      #1;
      check("R3", "no irq before edge", 32'(cpu_irq), 32'h0);
      @(negedge clk);
      check("R3", "irq one edge later", 32'(cpu_irq), 32'h5);
      irq_lines[36] = 1'b0;
      @(negedge clk);
      check("R10", "irq falls without access", 32'(cpu_irq), 32'h0);

      // R5: whole-word replace
      bus_write(mask_addr(1, 2), 32'hF0F0_1234);
      bus_write(mask_addr(1, 2), 32'h0F0F_0001);
      bus_read(mask_addr(1, 2), rd);
      check("R5", "mask replaced", rd, 32'h0F0F_0001);

      // R6: pending write ignored
      bus_write(pend_addr(1, 2), 32'hFFFF_FFFF);
      bus_read(mask_addr(1, 2), rd);
      check("R6", "mask after pending write", rd, 32'h0F0F_0001);
      irq_lines[64 +: 32] = 32'hFFFF_FFFF;
      bus_read(pend_addr(1, 2), rd);
      check("R6", "pending after write", rd, 32'h0F0F_0001);
      check("R6", "cpu_irq cpu1", 32'(cpu_irq), 32'h2);

      // R8: read data holds
      repeat (3) @(negedge clk);
      check("R8", "rdata hold", bus_rdata, 32'h0F0F_0001);

      // R9: out-of-range
      bus_write(NC * BW, 32'hFFFF_FFFF);
      bus_write(31, 32'hFFFF_FFFF);
      bus_read(NC * BW, rd);
      check("R9", "oob read", rd, 32'h0);
      bus_read(31, rd);
      check("R9", "oob top read", rd, 32'h0);
      bus_read(mask_addr(0, 0), rd);
      check("R9", "bank0 mask untouched", rd, 32'h0);
      check("R9", "cpu_irq untouched", 32'(cpu_irq), 32'h2);

      report();
   end

endmodule